// File: doc/BRIEF.md
# Command-Queue I2C Master Sequencer

This block is the byte-level layer of an I2C controller. Software, or a DMA engine, pushes 11-bit command words into a transmit queue. Each word is either a byte to write or a request to read one byte. Each word also carries its own per-byte flags: repeated START before the byte, and STOP after it. The sequencer drains the queue in order. For each word it issues the primitive operations (START, repeated START, write byte, read byte, STOP) to a separate bit-level bus engine, which owns SCL/SDA timing. Bytes the engine reads are placed into a receive queue.

A small target register holds the slave address and a 10-bit addressing flag. Whenever the bus has to be (re)addressed, the sequencer generates the address byte or bytes itself. When the queue runs dry without a STOP request, the bus stays owned rather than released. Software can then append more words to the same transaction.

A NACK during addressing or on a written byte aborts the transfer, as does a lost arbitration. An abort latches a cause code, flushes both queues and blocks new work until software acknowledges it. Queue fill levels and two threshold flags are exported so that software can pace itself.

Top module: `i2cq_master`

## Requirements
- R1: After reset both queues are empty (levels 0), abort is 0, abort cause is 0, no engine request is raised, the bus is not held, tx_low is 1 and rx_ready is 0.
- R2: A command word is {restart[10], stop[9], read[8], data[7:0]}. Engine op codes are START=0, RESTART=1, WRITE=2, READ=3, STOP=4. Starting from a released bus, a word produces START, then a WRITE of the 7-bit address byte {addr[6:0], read}, then the data operation.
- R3: A word with its stop bit set is followed by a STOP, which releases the bus. A READ is requested with eng_rd_nack=1 exactly when its word has the stop bit set, and with eng_rd_nack=0 otherwise.
- R4: When the queue empties after a word without the stop bit, no STOP is issued, bus_hold is 1 and no further engine request appears.
- R5: On a held bus, a word with the restart bit set is preceded by RESTART and a fresh address, even if the direction is unchanged. Otherwise it proceeds directly to its data operation.
- R6: On a held bus, a word whose read bit differs from the previous word's read bit is preceded by RESTART and a fresh address, without needing the restart bit.
- R7: Each read word pushes the byte returned by the engine into the receive queue, in order. The data bits of a read word have no effect.
- R8: With target bit 12 set, addressing uses 10 bits (target bits 9:0). A write sends {11110, a[9:8], 0} and then a[7:0]. A read then adds RESTART and {11110, a[9:8], 1}.
- R9: A NACK on any address byte sets abort, sets cause bit 0, flushes both queues and issues STOP.
- R10: A NACK on a written data byte sets abort, sets cause bit 1, flushes both queues and issues STOP.
- R11: A lost arbitration sets abort, sets cause bit 2 and flushes both queues. No STOP is issued, and the bus is considered released, so the next transfer begins with START.
- R12: While abort is set, pushes are ignored and no word is issued. Pulsing abort_clr clears abort and the cause.
- R13: A read word waits while the receive queue is full and proceeds once space appears. tx_low is 1 when tx_level <= TX_THRESH (default TX_DEPTH/2). rx_ready is 1 when rx_level > RX_THRESH (default 0).
- R14: eng_req, eng_op and eng_wbyte stay constant from the raising of a request until the cycle in which eng_done is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_push | input | 1 | Push cmd_word into the transmit queue |
| cmd_word | input | 11 | Command word {restart, stop, read, data} |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_data | output | 8 | Head of the receive queue |
| tar_we | input | 1 | Write the target register |
| tar_wdata | input | 13 | Bits 9:0 address, bit 12 ten-bit mode |
| abort_clr | input | 1 | Acknowledge and clear an abort |
| tx_level | output | $clog2(TX_DEPTH)+1 | Transmit queue fill level |
| rx_level | output | $clog2(RX_DEPTH)+1 | Receive queue fill level |
| tx_low | output | 1 | Transmit level at or below threshold |
| rx_ready | output | 1 | Receive level above threshold |
| abort | output | 1 | Transfer aborted, awaiting clear |
| abort_src | output | 3 | Cause: bit0 address NACK, bit1 data NACK, bit2 arbitration lost |
| bus_hold | output | 1 | Bus owned and waiting for more words |
| eng_req | output | 1 | Operation request to the bus engine |
| eng_op | output | 3 | Operation code |
| eng_wbyte | output | 8 | Byte to transmit for WRITE |
| eng_rd_nack | output | 1 | Answer a READ with NACK |
| eng_done | input | 1 | Engine finished the current operation (one-cycle pulse) |
| eng_nack | input | 1 | Slave NACKed the written byte (valid with eng_done) |
| eng_arb_lost | input | 1 | Arbitration lost (valid with eng_done) |
| eng_rbyte | input | 8 | Byte read (valid with eng_done) |

## Verification
A word pushed on one clock edge is in the queue after that edge. If the sequencer is idle and the word is eligible, the engine request follows one edge later. An engine completion changes the state on the very edge that samples eng_done. That same edge updates the queue levels, the abort flag, the cause bits and bus_hold, so they are valid in the next half cycle. The bench drives and samples on the falling edge. It records every request at the moment its completion is returned, and compares the whole operation log against sequences derived from the requirements only once the request line has stayed low for a fixed quiet window. It therefore never depends on the exact edge at which an intermediate operation starts.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

    typedef struct packed {
        logic       restart;
        logic       stop;
        logic       rd;
        logic [7:0] data;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RESTART = 3'd1,
        OP_WRITE   = 3'd2,
        OP_READ    = 3'd3,
        OP_STOP    = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_RESTART_RD,
        ST_ADDR_HI_RD,
        ST_DATA,
        ST_STOP
    } seq_st_e;

    localparam int SRC_ADDR = 0;
    localparam int SRC_DATA = 1;
    localparam int SRC_ARB  = 2;

    function automatic logic [7:0] addr7_byte(input logic [9:0] a, input logic rd);
        return {a[6:0], rd};
    endfunction

    function automatic logic [7:0] addr10_hi(input logic [9:0] a, input logic rd);
        return {5'b11110, a[9:8], rd};
    endfunction

endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  logic                   push,
    input  logic [W-1:0]           din,
    input  logic                   pop,
    output logic [W-1:0]           dout,
    output logic [$clog2(DEPTH):0] level,
    output logic                   full,
    output logic                   empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;
    logic         do_push, do_pop;

    assign level   = wp - rp;
    assign full    = (level == DEPTH_V);
    assign empty   = (level == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp[AW-1:0]] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
        end
    end
endmodule

// File: rtl/i2cq_seq.sv
module i2cq_seq
    import i2cq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cmd_t       cmd,
    input  logic       cmd_valid,
    input  logic       rx_full,
    input  logic       ten_bit,
    input  logic [9:0] taddr,
    input  logic       abort_clr,
    input  logic       eng_done,
    input  logic       eng_nack,
    input  logic       eng_arb_lost,
    output logic       cmd_pop,
    output logic       rx_push,
    output logic       flush,
    output logic       abort,
    output logic [2:0] abort_src,
    output logic       bus_hold,
    output logic       eng_req,
    output op_e        eng_op,
    output logic [7:0] eng_wbyte,
    output logic       eng_rd_nack
);
    seq_st_e    st;
    logic       owned, last_rd, abort_q;
    logic [2:0] src_q;

    logic fin, arb_ev, addr_phase, nack_addr, nack_data, data_ok, go, need_addr;

    assign fin        = eng_req && eng_done;
    assign arb_ev     = fin && eng_arb_lost;
    assign addr_phase = (st == ST_ADDR_HI) || (st == ST_ADDR_LO) || (st == ST_ADDR_HI_RD);
    assign nack_addr  = fin && !eng_arb_lost && eng_nack && addr_phase;
    assign nack_data  = fin && !eng_arb_lost && eng_nack && (st == ST_DATA) && !cmd.rd;
    assign data_ok    = fin && !eng_arb_lost && (st == ST_DATA) && !nack_data;
    assign go         = cmd_valid && !abort_q && !(cmd.rd && rx_full);
    assign need_addr  = !owned || cmd.restart || (cmd.rd != last_rd);

    assign cmd_pop   = data_ok;
    assign rx_push   = data_ok && cmd.rd;
    assign flush     = arb_ev || nack_addr || nack_data;
    assign abort     = abort_q;
    assign abort_src = src_q;
    assign bus_hold  = owned && (st == ST_IDLE);
    assign eng_req   = (st != ST_IDLE);

    always_comb begin
        eng_op      = OP_WRITE;
        eng_wbyte   = '0;
        eng_rd_nack = 1'b0;
        case (st)
            ST_START:      eng_op = owned ? OP_RESTART : OP_START;
            ST_ADDR_HI:    eng_wbyte = ten_bit ? addr10_hi(taddr, 1'b0) : addr7_byte(taddr, cmd.rd);
            ST_ADDR_LO:    eng_wbyte = taddr[7:0];
            ST_RESTART_RD: eng_op = OP_RESTART;
            ST_ADDR_HI_RD: eng_wbyte = addr10_hi(taddr, 1'b1);
            ST_DATA: begin
                eng_op      = cmd.rd ? OP_READ : OP_WRITE;
                eng_wbyte   = cmd.rd ? 8'h00 : cmd.data;
                eng_rd_nack = cmd.rd && cmd.stop;
            end
            ST_STOP:       eng_op = OP_STOP;
            default:       eng_op = OP_WRITE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            owned   <= 1'b0;
            last_rd <= 1'b0;
            abort_q <= 1'b0;
            src_q   <= '0;
        end else begin
            if (abort_clr) begin
                abort_q <= 1'b0;
                src_q   <= '0;
            end
            if (arb_ev) begin
                abort_q        <= 1'b1;
                src_q[SRC_ARB] <= 1'b1;
                owned          <= 1'b0;
                st             <= ST_IDLE;
            end else if (nack_addr) begin
                abort_q         <= 1'b1;
                src_q[SRC_ADDR] <= 1'b1;
                st              <= ST_STOP;
            end else if (nack_data) begin
                abort_q         <= 1'b1;
                src_q[SRC_DATA] <= 1'b1;
                st              <= ST_STOP;
            end else begin
                case (st)
                    ST_IDLE:       if (go) st <= need_addr ? ST_START : ST_DATA;
                    ST_START:      if (fin) begin owned <= 1'b1; st <= ST_ADDR_HI; end
                    ST_ADDR_HI:    if (fin) st <= ten_bit ? ST_ADDR_LO : ST_DATA;
                    ST_ADDR_LO:    if (fin) st <= cmd.rd ? ST_RESTART_RD : ST_DATA;
                    ST_RESTART_RD: if (fin) st <= ST_ADDR_HI_RD;
                    ST_ADDR_HI_RD: if (fin) st <= ST_DATA;
                    ST_DATA: if (fin) begin
                        last_rd <= cmd.rd;
                        st      <= cmd.stop ? ST_STOP : ST_IDLE;
                    end
                    ST_STOP:       if (fin) begin owned <= 1'b0; st <= ST_IDLE; end
                    default:       st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cq_master.sv
module i2cq_master
    import i2cq_pkg::*;
#(
    parameter int TX_DEPTH  = 8,
    parameter int RX_DEPTH  = 8,
    parameter int TX_THRESH = TX_DEPTH / 2,
    parameter int RX_THRESH = 0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cmd_push,
    input  logic [10:0]               cmd_word,
    input  logic                      rx_pop,
    output logic [7:0]                rx_data,
    input  logic                      tar_we,
    input  logic [12:0]               tar_wdata,
    input  logic                      abort_clr,
    output logic [$clog2(TX_DEPTH):0] tx_level,
    output logic [$clog2(RX_DEPTH):0] rx_level,
    output logic                      tx_low,
    output logic                      rx_ready,
    output logic                      abort,
    output logic [2:0]                abort_src,
    output logic                      bus_hold,
    output logic                      eng_req,
    output logic [2:0]                eng_op,
    output logic [7:0]                eng_wbyte,
    output logic                      eng_rd_nack,
    input  logic                      eng_done,
    input  logic                      eng_nack,
    input  logic                      eng_arb_lost,
    input  logic [7:0]                eng_rbyte
);
    localparam int TLW = $clog2(TX_DEPTH) + 1;
    localparam int RLW = $clog2(RX_DEPTH) + 1;
    localparam logic [TLW-1:0] TX_THR_V = TLW'(TX_THRESH);
    localparam logic [RLW-1:0] RX_THR_V = RLW'(RX_THRESH);

    logic             ten_q;
    logic [9:0]       addr_q;
    logic             unused_tar;
    logic [CMD_W-1:0] tx_head;
    cmd_t             cmd_head;
    logic             tx_empty, tx_full_unused, rx_full, rx_empty_unused;
    logic             cmd_pop, rx_push, flush, tx_push;
    op_e              op_w;

    assign unused_tar = ^{tar_wdata[11:10], tx_full_unused, rx_empty_unused};
    assign cmd_head   = cmd_t'(tx_head);
    assign tx_push    = cmd_push && !abort;
    assign eng_op     = op_w;
    assign tx_low     = (tx_level <= TX_THR_V);
    assign rx_ready   = (rx_level > RX_THR_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            ten_q  <= 1'b0;
            addr_q <= '0;
        end else if (tar_we) begin
            ten_q  <= tar_wdata[12];
            addr_q <= tar_wdata[9:0];
        end
    end

    i2cq_fifo #(.W(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(flush),
        .push(tx_push), .din(cmd_word),
        .pop(cmd_pop), .dout(tx_head),
        .level(tx_level), .full(tx_full_unused), .empty(tx_empty)
    );

    i2cq_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(flush),
        .push(rx_push), .din(eng_rbyte),
        .pop(rx_pop), .dout(rx_data),
        .level(rx_level), .full(rx_full), .empty(rx_empty_unused)
    );

    i2cq_seq u_seq (
        .clk(clk), .rst(rst),
        .cmd(cmd_head), .cmd_valid(!tx_empty), .rx_full(rx_full),
        .ten_bit(ten_q), .taddr(addr_q), .abort_clr(abort_clr),
        .eng_done(eng_done), .eng_nack(eng_nack), .eng_arb_lost(eng_arb_lost),
        .cmd_pop(cmd_pop), .rx_push(rx_push), .flush(flush),
        .abort(abort), .abort_src(abort_src), .bus_hold(bus_hold),
        .eng_req(eng_req), .eng_op(op_w), .eng_wbyte(eng_wbyte),
        .eng_rd_nack(eng_rd_nack)
    );
endmodule

// File: rtl/i2cq_master_chk.sv
module i2cq_master_chk #(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      eng_req,
    input logic [2:0]                eng_op,
    input logic [7:0]                eng_wbyte,
    input logic                      eng_done,
    input logic                      eng_arb_lost,
    input logic                      abort,
    input logic [2:0]                abort_src,
    input logic                      bus_hold,
    input logic [$clog2(TX_DEPTH):0] tx_level,
    input logic [$clog2(RX_DEPTH):0] rx_level
);
    p_req_held_r14: assert property (@(posedge clk) disable iff (rst)
        (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_wbyte)));

    p_no_overflow_r13: assert property (@(posedge clk) disable iff (rst)
        (32'(tx_level) <= TX_DEPTH) && (32'(rx_level) <= RX_DEPTH));

    p_flush_on_abort_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(abort) |-> (tx_level == '0) && (rx_level == '0));

    p_push_ignored_r12: assert property (@(posedge clk) disable iff (rst)
        abort |=> (tx_level == '0));

    p_arb_release_r11: assert property (@(posedge clk) disable iff (rst)
        (eng_req && eng_done && eng_arb_lost) |=> (!eng_req && !bus_hold && abort && abort_src[2]));

    p_abort_has_cause_r10: assert property (@(posedge clk) disable iff (rst)
        abort |-> (abort_src != 3'b000));
endmodule

bind i2cq_master i2cq_master_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
    .clk(clk), .rst(rst), .eng_req(eng_req), .eng_op(eng_op), .eng_wbyte(eng_wbyte),
    .eng_done(eng_done), .eng_arb_lost(eng_arb_lost), .abort(abort), .abort_src(abort_src),
    .bus_hold(bus_hold), .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/i2cq_master_bench.sv
module i2cq_master_bench;
    localparam int OP_START = 0, OP_RESTART = 1, OP_WRITE = 2, OP_READ = 3, OP_STOP = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_push = 1'b0;
    logic [10:0] cmd_word = '0;
    logic        rx_pop = 1'b0;
    logic [7:0]  rx_data;
    logic        tar_we = 1'b0;
    logic [12:0] tar_wdata = '0;
    logic        abort_clr = 1'b0;
    logic [3:0]  tx_level, rx_level;
    logic        tx_low, rx_ready, abort, bus_hold;
    logic [2:0]  abort_src;
    logic        eng_req, eng_rd_nack;
    logic [2:0]  eng_op;
    logic [7:0]  eng_wbyte;
    logic        eng_done = 1'b0, eng_nack = 1'b0, eng_arb_lost = 1'b0;
    logic [7:0]  eng_rbyte = '0;

    int checks = 0, fails = 0;
    int n_ops = 0, base = 0;
    int nack_idx = -1, arb_idx = -1;
    int op_log [1024];
    int byte_log [1024];
    int rdn_log [1024];

    always #2 clk = ~clk;

    i2cq_master u_i2cq_master (
        .clk(clk), .rst(rst), .cmd_push(cmd_push), .cmd_word(cmd_word),
        .rx_pop(rx_pop), .rx_data(rx_data), .tar_we(tar_we), .tar_wdata(tar_wdata),
        .abort_clr(abort_clr), .tx_level(tx_level), .rx_level(rx_level),
        .tx_low(tx_low), .rx_ready(rx_ready), .abort(abort), .abort_src(abort_src),
        .bus_hold(bus_hold), .eng_req(eng_req), .eng_op(eng_op), .eng_wbyte(eng_wbyte),
        .eng_rd_nack(eng_rd_nack), .eng_done(eng_done), .eng_nack(eng_nack),
        .eng_arb_lost(eng_arb_lost), .eng_rbyte(eng_rbyte)
    );

    // bus engine model: completes each request two cycles after it is seen
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                eng_done = 0; cnt = 0;
            end else if (eng_done) begin
                eng_done = 0; eng_nack = 0; eng_arb_lost = 0; cnt = 0;
            end else if (eng_req) begin
                if (cnt == 2) begin
                    if (n_ops < 1024) begin
                        op_log[n_ops]   = int'(eng_op);
                        byte_log[n_ops] = int'(eng_wbyte);
                        rdn_log[n_ops]  = int'(eng_rd_nack);
                    end
                    eng_nack     = (n_ops == nack_idx);
                    eng_arb_lost = (n_ops == arb_idx);
                    eng_rbyte    = 8'h3C ^ n_ops[7:0];
                    eng_done     = 1;
                    n_ops++;
                end else begin
                    cnt++;
                end
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R14 watchdog act=hung exp=finished");
        summary();
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_op(input string tag, input int k, input int op, input int b);
        chk({tag, " op"}, op_log[base+k], op);
        if (op == OP_WRITE) chk({tag, " byte"}, byte_log[base+k], b);
        if (op == OP_READ)  chk({tag, " rd_nack"}, rdn_log[base+k], b);
    endtask

    task automatic push(input logic [10:0] w);
        @(negedge clk); cmd_push = 1; cmd_word = w;
        @(negedge clk); cmd_push = 0;
    endtask

    task automatic set_tar(input logic [12:0] v);
        @(negedge clk); tar_we = 1; tar_wdata = v;
        @(negedge clk); tar_we = 0;
    endtask

    task automatic clear_abort();
        @(negedge clk); abort_clr = 1;
        @(negedge clk); abort_clr = 0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        int guard = 0;
        while (q < 12 && guard < 4000) begin
            @(negedge clk);
            if (eng_req) q = 0; else q++;
            guard++;
        end
    endtask

    task automatic pop_chk(input string tag, input int exp);
        @(negedge clk);
        chk(tag, int'(rx_data), exp & 8'hFF);
        rx_pop = 1;
        @(negedge clk);
        rx_pop = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_level", int'(tx_level), 0);
        chk("R1 rx_level", int'(rx_level), 0);
        chk("R1 abort", int'(abort), 0);
        chk("R1 abort_src", int'(abort_src), 0);
        chk("R1 eng_req", int'(eng_req), 0);
        chk("R1 bus_hold", int'(bus_hold), 0);
        chk("R1 tx_low", int'(tx_low), 1);
        chk("R1 rx_ready", int'(rx_ready), 0);

        // R2/R3: 7-bit write of two bytes with stop
        set_tar(13'h02A);
        base = n_ops;
        push(11'h011); push(11'h2A5);
        wait_quiet();
        chk("R2 count", n_ops - base, 5);
        chk_op("R2 start", 0, OP_START, 0);
        chk_op("R2 addr", 1, OP_WRITE, 8'h54);
        chk_op("R2 d0", 2, OP_WRITE, 8'h11);
        chk_op("R3 d1", 3, OP_WRITE, 8'hA5);
        chk_op("R3 stop", 4, OP_STOP, 0);
        chk("R3 released", int'(bus_hold), 0);

        // R4 hold, then R6 direction change and R7 reads
        base = n_ops;
        push(11'h033);
        wait_quiet();
        chk("R4 count", n_ops - base, 3);
        chk("R4 bus_hold", int'(bus_hold), 1);
        push(11'h1FF); push(11'h300);
        wait_quiet();
        chk("R6 count", n_ops - base, 8);
        chk_op("R6 restart", 3, OP_RESTART, 0);
        chk_op("R6 addr", 4, OP_WRITE, 8'h55);
        chk_op("R3 read ack", 5, OP_READ, 0);
        chk_op("R3 read nack", 6, OP_READ, 1);
        chk_op("R3 stop", 7, OP_STOP, 0);
        chk("R7 rx_level", int'(rx_level), 2);
        chk("R13 rx_ready", int'(rx_ready), 1);
        pop_chk("R7 rx0", 8'h3C ^ (base + 5));
        pop_chk("R7 rx1", 8'h3C ^ (base + 6));

        // R5 restart bit with unchanged direction
        base = n_ops;
        push(11'h044); push(11'h666);
        wait_quiet();
        chk("R5 count", n_ops - base, 7);
        chk_op("R5 w0", 2, OP_WRITE, 8'h44);
        chk_op("R5 restart", 3, OP_RESTART, 0);
        chk_op("R5 addr", 4, OP_WRITE, 8'h54);
        chk_op("R5 w1", 5, OP_WRITE, 8'h66);
        chk_op("R5 stop", 6, OP_STOP, 0);

        // R8 ten-bit write then read
        set_tar(13'h12B5);
        base = n_ops;
        push(11'h0AA); push(11'h300);
        wait_quiet();
        chk("R8 count", n_ops - base, 11);
        chk_op("R8 hi", 1, OP_WRITE, 8'hF4);
        chk_op("R8 lo", 2, OP_WRITE, 8'hB5);
        chk_op("R8 data", 3, OP_WRITE, 8'hAA);
        chk_op("R8 rs1", 4, OP_RESTART, 0);
        chk_op("R8 hi2", 5, OP_WRITE, 8'hF4);
        chk_op("R8 lo2", 6, OP_WRITE, 8'hB5);
        chk_op("R8 rs2", 7, OP_RESTART, 0);
        chk_op("R8 hird", 8, OP_WRITE, 8'hF5);
        chk_op("R8 read", 9, OP_READ, 1);
        chk_op("R8 stop", 10, OP_STOP, 0);
        pop_chk("R8 rx", 8'h3C ^ (base + 9));

        // R9 address NACK, R12 pushes ignored and clear
        set_tar(13'h02A);
        base = n_ops; nack_idx = base + 1;
        push(11'h011); push(11'h022); push(11'h233);
        wait_quiet();
        nack_idx = -1;
        chk("R9 count", n_ops - base, 3);
        chk_op("R9 stop", 2, OP_STOP, 0);
        chk("R9 abort", int'(abort), 1);
        chk("R9 src", int'(abort_src), 1);
        chk("R9 tx_level", int'(tx_level), 0);
        push(11'h244);
        wait_quiet();
        chk("R12 tx_level", int'(tx_level), 0);
        chk("R12 no ops", n_ops - base, 3);
        clear_abort();
        @(negedge clk);
        chk("R12 abort clr", int'(abort), 0);
        chk("R12 src clr", int'(abort_src), 0);

        // R10 data NACK flushes receive queue
        base = n_ops;
        push(11'h100);
        wait_quiet();
        chk("R10 rx before", int'(rx_level), 1);
        nack_idx = base + 5;
        push(11'h077);
        wait_quiet();
        nack_idx = -1;
        chk("R10 count", n_ops - base, 7);
        chk_op("R10 w", 5, OP_WRITE, 8'h77);
        chk_op("R10 stop", 6, OP_STOP, 0);
        chk("R10 src", int'(abort_src), 2);
        chk("R10 rx flushed", int'(rx_level), 0);
        clear_abort();

        // R11 arbitration loss: no STOP, next transfer starts fresh
        base = n_ops; arb_idx = base + 1;
        push(11'h011);
        wait_quiet();
        arb_idx = -1;
        chk("R11 count", n_ops - base, 2);
        chk("R11 src", int'(abort_src), 4);
        chk("R11 bus_hold", int'(bus_hold), 0);
        clear_abort();
        base = n_ops;
        push(11'h211);
        wait_quiet();
        chk("R11 count2", n_ops - base, 4);
        chk_op("R11 start", 0, OP_START, 0);

        // R13 receive-full stall and thresholds
        base = n_ops;
        for (int i = 0; i < 8; i++) push(11'h1A0);
        wait_quiet();
        chk("R13 count", n_ops - base, 10);
        chk("R13 rx full", int'(rx_level), 8);
        for (int i = 0; i < 4; i++) push(11'h100);
        push(11'h300);
        wait_quiet();
        chk("R13 stalled", n_ops - base, 10);
        chk("R13 tx_level", int'(tx_level), 5);
        chk("R13 tx_low", int'(tx_low), 0);
        for (int j = 0; j < 13; j++) begin
            if (j == 8) wait_quiet();
            pop_chk("R7 R13 rx order", 8'h3C ^ (base + 2 + j));
        end
        wait_quiet();
        chk("R13 total", n_ops - base, 16);
        chk_op("R13 last read", 14, OP_READ, 1);
        chk("R13 tx_low after", int'(tx_low), 1);

        // R2/R3 sweep over 7-bit addresses, alternating direction
        for (int a = 3, it = 0; a < 128; a += 11, it++) begin
            set_tar(13'(a));
            base = n_ops;
            if (it % 2 == 0) begin
                push(11'h200 | 11'((a ^ 8'h5A) & 8'hFF));
                wait_quiet();
                chk("R2 sweep count", n_ops - base, 4);
                chk_op("R2 sweep addr", 1, OP_WRITE, (a << 1) & 8'hFF);
                chk_op("R2 sweep data", 2, OP_WRITE, (a ^ 8'h5A) & 8'hFF);
            end else begin
                push(11'h300 | 11'(a & 8'hFF));
                wait_quiet();
                chk("R3 sweep count", n_ops - base, 4);
                chk_op("R3 sweep addr", 1, OP_WRITE, ((a << 1) | 1) & 8'hFF);
                chk_op("R3 sweep read", 2, OP_READ, 1);
                pop_chk("R7 sweep rx", 8'h3C ^ (base + 2));
            end
            chk_op("R3 sweep stop", 3, OP_STOP, 0);
        end

        summary();
        $finish;
    end
endmodule